// File: doc/BRIEF.md
# Two-Stage Wormhole Router Input Port

This block is one input port of a wormhole-switched mesh router. Flits come in from the upstream link. They wait in a small in-order buffer. When a packet's opening flit reaches the front of the buffer, it spends one cycle in route computation, where dimension-ordered XY routing picks an output port. From the next cycle on, the port requests that output from an external switch allocator.

When the grant arrives, the front flit is dequeued and presented to the crossbar in that same cycle. A credit pulse returns to the upstream router in that cycle as well. In the following cycle, the flit appears registered on the link stage.

Once a packet has its route, its body and tail flits reuse the stored output port without new route computation. The stored route is dropped when the packet's last flit leaves.

A parameter selects how the buffer is shared between packets:
- **Non-atomic:** a new packet may queue directly behind the previous packet's tail.
- **Atomic:** once a packet's last flit has been accepted, the port refuses input until the buffer has fully drained.

Top module: `wh_input_port`

## Requirements
- R1: After reset, in_ready is 1, and sw_req, xbar_valid, credit_out and link_valid are all 0.
- R2: A flit is {type[1:0], payload}, with type 00 head, 01 body, 10 tail and 11 single-flit packet. A head or single flit accepted at clock edge E into an empty port spends the next cycle in route computation with sw_req low. sw_req rises after edge E+1.
- R3: The destination x sits in payload bits [COORD_W-1:0] and y in [2*COORD_W-1:COORD_W]. The output is chosen in this order: east (1) if x is larger than the port's own x; west (2) if x is smaller; north (3) if y is larger; south (4) if y is smaller; otherwise local (0).
- R4: While sw_req is high and sw_grant is low, sw_req stays high in the next cycle with an unchanged sw_req_port. The packet is only delayed by the lost cycles.
- R5: In a cycle where sw_req and sw_grant are both high, xbar_valid and credit_out are high. xbar_flit carries the front flit and xbar_port carries the stored route.
- R6: One cycle after xbar_valid, link_valid is high, with link_flit and link_port equal to the previous xbar_flit and xbar_port.
- R7: Flits leave in arrival order. A body or tail flit requests in the cycle right after the previous flit of its packet leaves, using the packet's stored port.
- R8: Dequeuing a tail or single flit clears the stored route. sw_req is low in the next cycle, and the next packet's head leaves no sooner than two cycles after it.
- R9: in_ready is low while the buffer holds DEPTH flits, and a flit offered while in_ready is low is dropped. With non-atomic allocation, flits of a new packet are accepted behind a buffered tail.
- R10: With atomic allocation, after a tail or single flit is accepted, in_ready stays low until the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream flit present |
| in_flit | input | PAYLOAD_W+2 | Incoming flit |
| in_ready | output | 1 | Port accepts a flit this cycle |
| credit_out | output | 1 | One-cycle credit return per dequeue |
| sw_req | output | 1 | Request to the switch allocator |
| sw_req_port | output | 3 | Requested output port |
| sw_grant | input | 1 | Allocator grant |
| xbar_valid | output | 1 | Flit driven into the crossbar |
| xbar_flit | output | PAYLOAD_W+2 | Crossbar flit |
| xbar_port | output | 3 | Crossbar output select |
| link_valid | output | 1 | Flit on the link stage |
| link_flit | output | PAYLOAD_W+2 | Link-stage flit |
| link_port | output | 3 | Link-stage output port |

## Verification
The embedded assertions check four behaviours on every cycle:
- a denied request is held with a stable port;
- the link stage follows the crossbar by exactly one cycle;
- the request drops after a packet ends;
- the atomic lock engages after a last flit is accepted, and the occupancy never exceeds the depth.

Route values, FIFO ordering, the one-cycle route-computation bubble and the exact cycle spacing of flits can only be shown by the bench's scenarios. The same holds for dropping flits at a full buffer, for a new packet queuing behind a tail, and for how long the atomic lock lasts. The bench covers these with a scoreboard on the link outputs plus timing probes.

// File: rtl/wh_input_port.sv
module wh_input_port #(
  parameter int COORD_W   = 2,
  parameter int PAYLOAD_W = 8,
  parameter int DEPTH     = 4,
  parameter bit ATOMIC    = 1'b0,
  parameter int MY_X      = 1,
  parameter int MY_Y      = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [PAYLOAD_W+1:0] in_flit,
  output logic                 in_ready,
  output logic                 credit_out,
  output logic                 sw_req,
  output logic [2:0]           sw_req_port,
  input  logic                 sw_grant,
  output logic                 xbar_valid,
  output logic [PAYLOAD_W+1:0] xbar_flit,
  output logic [2:0]           xbar_port,
  output logic                 link_valid,
  output logic [PAYLOAD_W+1:0] link_flit,
  output logic [2:0]           link_port
);
  localparam int FLIT_W = PAYLOAD_W + 2;
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam logic [1:0] T_HEAD = 2'b00, T_TAIL = 2'b10, T_SOLO = 2'b11;
  localparam logic [2:0] P_LOCAL = 3'd0, P_EAST = 3'd1, P_WEST = 3'd2,
                         P_NORTH = 3'd3, P_SOUTH = 3'd4;

  logic [FLIT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [CNT_W-1:0]  count;
  logic              route_vld, locked;
  logic [2:0]        route_port, rc_port;

  wire [FLIT_W-1:0] front      = mem[rd_ptr];
  wire [1:0]        front_type = front[FLIT_W-1 -: 2];
  wire [1:0]        in_type    = in_flit[FLIT_W-1 -: 2];
  wire              front_vld  = count != '0;
  wire              front_start = front_type == T_HEAD || front_type == T_SOLO;
  wire              front_end   = front_type == T_TAIL || front_type == T_SOLO;
  wire              in_end      = in_type == T_TAIL || in_type == T_SOLO;
  wire              full        = count == CNT_W'(DEPTH);
  wire [COORD_W-1:0] dst_x = front[COORD_W-1:0];
  wire [COORD_W-1:0] dst_y = front[2*COORD_W-1:COORD_W];

  assign in_ready    = !full && !(ATOMIC && locked && front_vld);
  wire   wr          = in_valid && in_ready;
  assign sw_req      = front_vld && route_vld;
  assign sw_req_port = route_port;
  wire   deq         = sw_req && sw_grant;
  wire   do_rc       = front_vld && front_start && !route_vld;

  assign xbar_valid = deq;
  assign xbar_flit  = front;
  assign xbar_port  = route_port;
  assign credit_out = deq;

  always_comb begin
    if (int'(dst_x) > MY_X)      rc_port = P_EAST;
    else if (int'(dst_x) < MY_X) rc_port = P_WEST;
    else if (int'(dst_y) > MY_Y) rc_port = P_NORTH;
    else if (int'(dst_y) < MY_Y) rc_port = P_SOUTH;
    else                         rc_port = P_LOCAL;
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wr_ptr] <= in_flit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr)  wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (deq) rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({wr, deq})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_vld  <= 1'b0;
      route_port <= P_LOCAL;
    end else if (deq && front_end) begin
      route_vld  <= 1'b0;
    end else if (do_rc) begin
      route_vld  <= 1'b1;
      route_port <= rc_port;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             locked <= 1'b0;
    else if (wr && in_end)  locked <= 1'b1;
    else if (!front_vld)    locked <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_valid <= 1'b0;
      link_flit  <= '0;
      link_port  <= P_LOCAL;
    end else begin
      link_valid <= deq;
      if (deq) begin
        link_flit <= front;
        link_port <= route_port;
      end
    end
  end

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req && !sw_grant |=> sw_req && $stable(sw_req_port));

  assert_link_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xbar_valid |=> link_valid && link_flit == $past(xbar_flit) && link_port == $past(xbar_port));

  assert_route_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xbar_valid && (xbar_flit[FLIT_W-1 -: 2] == T_TAIL || xbar_flit[FLIT_W-1 -: 2] == T_SOLO)
    |=> !sw_req);

  assert_atomic_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ATOMIC && in_valid && in_ready && in_end |=> !in_ready);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
endmodule

// File: tb/wh_input_port_bench.sv
module wh_input_port_bench;
  localparam int CW = 2, PW = 8, FW = PW + 2;
  localparam logic [1:0] HD = 2'b00, BD = 2'b01, TL = 2'b10, SO = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic in_valid = 1'b0, in_ready, credit_out, sw_req, sw_grant = 1'b0;
  logic xbar_valid, link_valid;
  logic [FW-1:0] in_flit = '0, xbar_flit, link_flit;
  logic [2:0] sw_req_port, xbar_port, link_port;

  wh_input_port #(.COORD_W(CW), .PAYLOAD_W(PW), .DEPTH(4), .ATOMIC(1'b0)) u_wh_input_port (
    .clk, .rst_n, .in_valid, .in_flit, .in_ready, .credit_out, .sw_req, .sw_req_port,
    .sw_grant, .xbar_valid, .xbar_flit, .xbar_port, .link_valid, .link_flit, .link_port);

  logic a_valid = 1'b0, a_ready, a_cr, a_req, a_xv, a_lv;
  logic [FW-1:0] a_flit = '0, a_xf, a_lf;
  logic [2:0] a_rp, a_xp, a_lp;
  wh_input_port #(.COORD_W(CW), .PAYLOAD_W(PW), .DEPTH(4), .ATOMIC(1'b1)) u_wh_input_port_atm (
    .clk, .rst_n, .in_valid(a_valid), .in_flit(a_flit), .in_ready(a_ready), .credit_out(a_cr),
    .sw_req(a_req), .sw_req_port(a_rp), .sw_grant(a_req), .xbar_valid(a_xv), .xbar_flit(a_xf),
    .xbar_port(a_xp), .link_valid(a_lv), .link_flit(a_lf), .link_port(a_lp));

  int n_chk = 0, n_fail = 0, m_chk = 0, m_fail = 0;
  int cyc = 0, deny_lim = 0, run_den = 0, den_total = 0;
  int x_cnt = 0, x_last = 0, x_prev = 0, a_links = 0;
  logic [FW-1:0] exp_flit [64];
  logic [2:0]    exp_port [64];
  int wr_idx = 0, rd_idx = 0;
  logic [2:0] cur_port = 3'd0;

  function automatic logic [2:0] xy_ref(int x, int y);
    if (x > 1) return 3'd1;
    if (x < 1) return 3'd2;
    if (y > 1) return 3'd3;
    if (y < 1) return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [FW-1:0] mk(logic [1:0] t, int x, int y, int tag);
    return {t, 4'(tag), 2'(y), 2'(x)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] t, input int x, input int y, input int tag);
    logic [FW-1:0] f = mk(t, x, y, tag);
    if (t == HD || t == SO) cur_port = xy_ref(x, y);
    @(negedge clk);
    in_valid = 1'b1;
    in_flit  = f;
    while (!in_ready) @(negedge clk);
    exp_flit[wr_idx] = f;
    exp_port[wr_idx] = cur_port;
    wr_idx++;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // allocator model and scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    #1;
    if (sw_req && run_den < deny_lim) begin
      sw_grant = 1'b0;
      run_den++;
      den_total++;
    end else begin
      sw_grant = sw_req;
    end
    #1;
    if (xbar_valid) begin
      m_chk++;
      if (!credit_out || xbar_port != sw_req_port) begin
        m_fail++;
        $display("FAIL R5 actual=%0d expected=%0d", credit_out, 1);
      end
      x_prev = x_last;
      x_last = cyc;
      x_cnt++;
      if (xbar_flit[FW-1] == 1'b1) run_den = 0;
    end
    if (link_valid) begin
      m_chk++;
      if (rd_idx >= wr_idx) begin
        m_fail++;
        $display("FAIL R7 actual=%0d expected=%0d", link_flit, 0);
      end else begin
        if (link_flit != exp_flit[rd_idx] || link_port != exp_port[rd_idx]) begin
          m_fail++;
          $display("FAIL R3/R7 actual=%0h/%0d expected=%0h/%0d",
                   link_flit, link_port, exp_flit[rd_idx], exp_port[rd_idx]);
        end
        rd_idx++;
      end
    end
    if (a_lv) a_links++;
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + m_chk, n_fail + m_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int n;
    int d0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #3;
    chk(in_ready && !sw_req && !xbar_valid && !credit_out && !link_valid, "R1",
        {in_ready, sw_req, xbar_valid, credit_out, link_valid}, 5'b10000);

    // R2/R3: single flit going east, route-computation bubble then request
    send(SO, 2, 1, 1);
    @(negedge clk); #3;
    chk(!sw_req, "R2", sw_req, 0);
    @(negedge clk); #3;
    chk(sw_req && sw_req_port == 3'd1, "R2_R3", sw_req_port, 1);
    chk(xbar_valid && credit_out, "R5", xbar_valid, 1);
    repeat (4) @(negedge clk);

    // R7: three-flit packet north, back-to-back departures
    send(HD, 1, 3, 2); send(BD, 0, 0, 3); send(TL, 0, 0, 4);
    repeat (8) @(negedge clk);
    chk(x_last - x_prev == 1, "R7", x_last - x_prev, 1);

    // R4: head west denied three times
    d0 = den_total;
    deny_lim = 3;
    send(HD, 0, 1, 5); send(BD, 0, 0, 6); send(TL, 0, 0, 7);
    repeat (12) @(negedge clk);
    deny_lim = 0;
    chk(den_total - d0 == 3, "R4", den_total - d0, 3);
    chk(x_last - x_prev == 1, "R7", x_last - x_prev, 1);

    // R8: two single flits back to back, route bubble between them
    send(SO, 1, 2, 8); send(SO, 1, 1, 9);
    repeat (8) @(negedge clk);
    chk(x_last - x_prev == 2, "R8", x_last - x_prev, 2);

    // R9: fill buffer with head denied, offered flits while full are dropped
    deny_lim = 10;
    send(HD, 1, 0, 10); send(BD, 0, 0, 11); send(BD, 0, 0, 12); send(BD, 0, 0, 13);
    @(negedge clk);
    chk(!in_ready, "R9", in_ready, 0);
    in_valid = 1'b1; in_flit = mk(BD, 0, 0, 15);
    @(negedge clk);
    chk(!in_ready, "R9", in_ready, 0);
    in_valid = 1'b0;
    send(TL, 0, 0, 14);
    repeat (12) @(negedge clk);
    deny_lim = 0;

    // R9: non-atomic, new packet accepted behind a buffered tail
    deny_lim = 5;
    send(HD, 2, 2, 1); send(TL, 0, 0, 2);
    @(negedge clk);
    chk(in_ready, "R9", in_ready, 1);
    send(SO, 1, 1, 3);
    repeat (14) @(negedge clk);
    deny_lim = 0;
    chk(rd_idx == wr_idx, "R7", rd_idx, wr_idx);

    // R10: atomic lock until empty
    @(negedge clk); a_valid = 1'b1; a_flit = mk(HD, 2, 1, 1);
    @(negedge clk); a_flit = mk(TL, 0, 0, 2);
    @(negedge clk); a_flit = mk(SO, 1, 1, 3);
    n = 0;
    while (!a_ready && n < 20) begin @(negedge clk); n++; end
    chk(n == 2, "R10", n, 2);
    @(negedge clk); a_valid = 1'b0;
    repeat (8) @(negedge clk);
    chk(a_links == 3, "R10", a_links, 3);
    finish_run();
  end
endmodule